// File: doc/BRIEF.md
# Interleaved Multiphase PWM Generator

This block drives up to four power-stage channels from one free-running switching-period counter. Each active channel builds its own sawtooth by shifting the shared count by a phase offset and compares that ramp with a duty command. The duty command starts from a common error word. A current-balance correction then trims it per channel, so a channel that carries more than its share gets shorter pulses. The analog front end (error amplifier, current sensing) sits outside the block and delivers its results as digital words.

While reset is held, the block reads a "tied high" sense line for every channel. A channel whose line is high is treated as absent, and the remaining channels are packed in index order into evenly spaced phase slots. Each output is a three-state code so a downstream driver can switch off both transistors. The error and current words are plain sampled levels with no handshake and no back-pressure. The block reads them only at each channel's own period boundary.

Top module: `interleaved_pwm`

## Requirements
- R1: While `rst` is high, every channel's 2-bit output code is high-impedance. The codes are 00 high-impedance, 01 low and 10 high. Code 11 is never produced.
- R2: The tied-high mask is sampled while `rst` is high and is frozen when reset is released. A channel whose bit was 1 stays at high-impedance from then on, and the active count N equals the number of 0 bits.
- R3: The shared counter runs from 0 to PERIOD-1. Active channels are ranked 0..N-1 by ascending index. The period of the channel with rank k begins k*floor(PERIOD/N) cycles after the period of rank 0.
- R4: With balanced currents, each active channel is high (10) for exactly `err_i` cycles out of every PERIOD cycles, as one pulse at the start of its own period, and low (01) for the rest.
- R5: The average current is floor(sum of active channels' currents / N). Inactive channels' currents are excluded from it. A channel whose current is above the average loses (current - average) << CSH cycles of high time.
- R6: A channel whose current is at or below the average keeps its uncorrected high time.
- R7: An error word above PERIOD is treated as PERIOD, which gives a fully high output. If a correction exceeds the error, the result is zero high time, never a wrapped value.
- R8: The error and current inputs are captured only at a channel's period boundary. A change in the middle of a period leaves the pulse in progress unchanged and takes effect in the next period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; outputs high-impedance while high |
| pin_tied_i | input | CH | Per-channel tied-high sense, read during reset |
| err_i | input | CW | Common duty command in counter cycles |
| isen_i | input | CH*IW | Sensed current per channel, channel i at bits [i*IW +: IW] |
| pwm_o | output | 2*CH | Per-channel output code, channel i at bits [2*i +: 2] |

## Verification
The bench goes after the active-count and phase-slot logic with four, three, two and one active channels. A wrong rank or step would show up as the wrong distance between rising edges, and a leaking mask bit would show up as an unused channel driving its pin. It sets up currents both above and below the average, and adds large currents on absent channels. A design that counted those channels or corrected the wrong way would give the wrong high time. The bench also probes both clamps, where an unclamped design would wrap to a short pulse. Finally it changes the error word halfway through a pulse, which a design that does not latch at the boundary would stretch at once.

// File: rtl/ipwm_pkg.sv
package ipwm_pkg;
  typedef enum logic [1:0] {
    PIN_HIZ  = 2'b00,
    PIN_LOW  = 2'b01,
    PIN_HIGH = 2'b10
  } pin_state_e;
endpackage

// File: rtl/ipwm_phase_map.sv
module ipwm_phase_map #(
  parameter int CH     = 4,
  parameter int CW     = 10,
  parameter int PERIOD = 1000,
  localparam int NW    = $clog2(CH + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [CH-1:0]         pin_tied_i,
  output logic [CH-1:0]         used_o,
  output logic [NW-1:0]         n_act_o,
  output logic [CH-1:0][CW-1:0] offset_o
);
  logic [CH-1:0] unused_q;
  logic [CW-1:0] step;

  // mask is followed during reset and frozen after release
  always_ff @(posedge clk) begin
    if (rst) unused_q <= pin_tied_i;
  end

  assign used_o = ~unused_q;

  always_comb begin
    n_act_o = '0;
    for (int i = 0; i < CH; i++) n_act_o = n_act_o + NW'(used_o[i]);
    step = '0;
    for (int k = 1; k <= CH; k++)
      if (n_act_o == NW'(k)) step = CW'(PERIOD / k);
  end

  // rank = number of used channels with a lower index
  always_comb begin
    int r;
    r = 0;
    for (int i = 0; i < CH; i++) begin
      offset_o[i] = CW'(r * int'(step));
      if (used_o[i]) r = r + 1;
    end
  end

  assert_step_fits_R3: assert property (@(posedge clk) disable iff (rst)
    (n_act_o != '0) |-> (int'(step) * int'(n_act_o) <= PERIOD));
endmodule

// File: rtl/ipwm_balance.sv
module ipwm_balance #(
  parameter int CH     = 4,
  parameter int CW     = 10,
  parameter int IW     = 8,
  parameter int PERIOD = 1000,
  parameter int CSH    = 2,
  localparam int NW    = $clog2(CH + 1),
  localparam int SW    = IW + NW,
  localparam int DW    = CW + 1
) (
  input  logic [CH-1:0]         used_i,
  input  logic [NW-1:0]         n_act_i,
  input  logic [CW-1:0]         err_i,
  input  logic [CH*IW-1:0]      isen_i,
  output logic [CH-1:0][DW-1:0] duty_o
);
  logic [SW-1:0] sum;
  logic [SW-1:0] avg;

  always_comb begin
    sum = '0;
    for (int i = 0; i < CH; i++)
      if (used_i[i]) sum = sum + SW'(isen_i[i*IW +: IW]);
    avg = '0;
    for (int k = 1; k <= CH; k++)
      if (n_act_i == NW'(k)) avg = sum / SW'(k);
  end

  always_comb begin
    int e;
    int c;
    int cur;
    e = (int'(err_i) > PERIOD) ? PERIOD : int'(err_i);
    for (int i = 0; i < CH; i++) begin
      cur = int'(isen_i[i*IW +: IW]);
      c = (cur > int'(avg)) ? ((cur - int'(avg)) << CSH) : 0;
      duty_o[i] = (e > c) ? DW'(e - c) : '0;
    end
  end
endmodule

// File: rtl/ipwm_channel.sv
module ipwm_channel
  import ipwm_pkg::*;
#(
  parameter int CW     = 10,
  parameter int PERIOD = 1000,
  localparam int DW    = CW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          act_i,
  input  logic          used_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] offset_i,
  input  logic [DW-1:0] duty_i,
  output pin_state_e    state_o
);
  logic [CW-1:0] saw;
  logic [DW-1:0] duty_q;

  always_comb begin
    if (cnt_i >= offset_i) saw = cnt_i - offset_i;
    else                   saw = cnt_i + CW'(PERIOD) - offset_i;
  end

  // new command takes effect exactly when the sawtooth restarts
  always_ff @(posedge clk) begin
    if (rst)                             duty_q <= '0;
    else if (saw == CW'(PERIOD - 1))     duty_q <= duty_i;
  end

  always_comb begin
    if (!(act_i && used_i))          state_o = PIN_HIZ;
    else if ({1'b0, saw} < duty_q)   state_o = PIN_HIGH;
    else                             state_o = PIN_LOW;
  end

  assert_unused_hiz_R2: assert property (@(posedge clk) disable iff (rst)
    !used_i |-> (state_o == PIN_HIZ));
  assert_duty_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (saw != '0) |-> $stable(duty_q));
  assert_duty_bound_R7: assert property (@(posedge clk) disable iff (rst)
    int'(duty_q) <= PERIOD);
endmodule

// File: rtl/interleaved_pwm.sv
module interleaved_pwm
  import ipwm_pkg::*;
#(
  parameter int CH     = 4,
  parameter int CW     = 10,
  parameter int PERIOD = 1000,
  parameter int IW     = 8,
  parameter int CSH    = 2,
  localparam int NW    = $clog2(CH + 1),
  localparam int DW    = CW + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [CH-1:0]   pin_tied_i,
  input  logic [CW-1:0]   err_i,
  input  logic [CH*IW-1:0] isen_i,
  output logic [2*CH-1:0] pwm_o
);
  logic [CW-1:0]         cnt_q;
  logic                  act_q;
  logic [CH-1:0]         used;
  logic [NW-1:0]         n_act;
  logic [CH-1:0][CW-1:0] offset;
  logic [CH-1:0][DW-1:0] duty_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else begin
      act_q <= 1'b1;
      cnt_q <= (cnt_q == CW'(PERIOD - 1)) ? '0 : cnt_q + 1'b1;
    end
  end

  assert_cnt_range_R3: assert property (@(posedge clk) disable iff (rst)
    int'(cnt_q) < PERIOD);

  ipwm_phase_map #(.CH(CH), .CW(CW), .PERIOD(PERIOD)) u_map (
    .clk(clk), .rst(rst), .pin_tied_i(pin_tied_i),
    .used_o(used), .n_act_o(n_act), .offset_o(offset));

  ipwm_balance #(.CH(CH), .CW(CW), .IW(IW), .PERIOD(PERIOD), .CSH(CSH)) u_bal (
    .used_i(used), .n_act_i(n_act), .err_i(err_i), .isen_i(isen_i),
    .duty_o(duty_c));

  for (genvar g = 0; g < CH; g++) begin : g_ch
    pin_state_e st;
    ipwm_channel #(.CW(CW), .PERIOD(PERIOD)) u_ch (
      .clk(clk), .rst(rst), .act_i(act_q), .used_i(used[g]),
      .cnt_i(cnt_q), .offset_i(offset[g]), .duty_i(duty_c[g]),
      .state_o(st));
    assign pwm_o[2*g +: 2] = st;
  end
endmodule

// File: tb/sim_interleaved_pwm.sv
`timescale 1ns/1ps
module sim_interleaved_pwm;
  localparam int P = 120;
  localparam int W = 2 * P;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0]  tied = '0;
  logic [9:0]  err = '0;
  logic [31:0] isen = '0;
  logic [7:0]  pwm;
  logic [1:0]  hist [0:3][0:W-1];
  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  interleaved_pwm #(.CH(4), .CW(10), .PERIOD(P), .IW(8), .CSH(2)) u0 (
    .clk(clk), .rst(rst), .pin_tied_i(tied), .err_i(err), .isen_i(isen), .pwm_o(pwm));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [3:0] t);
    tied = t;
    rst = 1'b1;
    repeat (4) @(negedge clk);
    chk(pwm == 8'h00, "R1 reset hi-z", int'(pwm), 0);
    rst = 1'b0;
  endtask

  task automatic capture();
    repeat (3 * P) @(negedge clk);
    for (int n = 0; n < W; n++) begin
      @(negedge clk);
      for (int c = 0; c < 4; c++) hist[c][n] = pwm[2*c +: 2];
    end
  endtask

  function automatic int highs(input int c);
    int h = 0;
    for (int n = 0; n < P; n++) if (hist[c][n] == 2'b10) h++;
    return h;
  endfunction

  function automatic int rise(input int c);
    for (int n = 1; n < W; n++)
      if (hist[c][n-1] == 2'b01 && hist[c][n] == 2'b10) return n;
    return -1000;
  endfunction

  function automatic bit all_hiz(input int c);
    for (int n = 0; n < W; n++) if (hist[c][n] != 2'b00) return 1'b0;
    return 1'b1;
  endfunction

  task automatic chk_gap(input int c0, input int ck, input int exp, input string req);
    int d = ((rise(ck) - rise(c0)) % P + P) % P;
    chk(d == exp, req, d, exp);
  endtask

  // R3 R4 R6: four channels, equal currents
  task automatic t_four();
    err = 10'd50; isen = {8'd10, 8'd10, 8'd10, 8'd10};
    do_reset(4'b0000);
    capture();
    for (int c = 0; c < 4; c++) chk(highs(c) == 50, "R4/R6 high time", highs(c), 50);
    chk_gap(0, 1, 30, "R3 rank1 slot");
    chk_gap(0, 2, 60, "R3 rank2 slot");
    chk_gap(0, 3, 90, "R3 rank3 slot");
  endtask

  // R2 R5 R6: channels 1 and 3 absent, skewed currents
  task automatic t_two();
    err = 10'd60; isen = {8'd200, 8'd10, 8'd200, 8'd20};
    do_reset(4'b1010);
    capture();
    chk(all_hiz(1), "R2 ch1 unused hi-z", int'(hist[1][0]), 0);
    chk(all_hiz(3), "R2 ch3 unused hi-z", int'(hist[3][0]), 0);
    chk(highs(0) == 40, "R5 above-average trimmed", highs(0), 40);
    chk(highs(2) == 60, "R6 below-average untouched", highs(2), 60);
    chk_gap(0, 2, 60, "R3 two-phase slot");
  endtask

  // R7 clamps, then R3 three-phase spacing
  task automatic t_three();
    err = 10'd1000; isen = {8'd0, 8'd0, 8'd0, 8'd100};
    do_reset(4'b1000);
    capture();
    chk(highs(0) == 0,  "R7 correction floors at zero", highs(0), 0);
    chk(highs(1) == P,  "R7 error clamps to period", highs(1), P);
    chk(highs(2) == P,  "R7 error clamps to period", highs(2), P);
    chk(all_hiz(3), "R2 ch3 unused hi-z", int'(hist[3][0]), 0);
    err = 10'd30; isen = {8'd5, 8'd5, 8'd5, 8'd5};
    capture();
    chk(highs(1) == 30, "R4 three-phase high time", highs(1), 30);
    chk_gap(0, 1, 40, "R3 third-period slot");
    chk_gap(0, 2, 80, "R3 third-period slot");
  endtask

  task automatic pulse_len(output int len);
    int guard = 0;
    logic [1:0] prev = pwm[1:0];
    while (!(prev == 2'b01 && pwm[1:0] == 2'b10) && guard < 3 * P) begin
      prev = pwm[1:0];
      @(negedge clk);
      guard++;
    end
    len = 1;
    for (int k = 0; k < P; k++) begin
      @(negedge clk);
      if (pwm[1:0] == 2'b10) len++; else break;
    end
  endtask

  // R8: mid-pulse change waits for the next period
  task automatic t_sample();
    int l1, l2, guard;
    logic [1:0] prev;
    err = 10'd40; isen = '0;
    do_reset(4'b0000);
    repeat (3 * P) @(negedge clk);
    prev = pwm[1:0]; guard = 0;
    @(negedge clk);
    while (!(prev == 2'b01 && pwm[1:0] == 2'b10) && guard < 3 * P) begin
      prev = pwm[1:0];
      @(negedge clk);
      guard++;
    end
    l1 = 1;
    for (int k = 0; k < P; k++) begin
      @(negedge clk);
      if (k == 4) err = 10'd80;
      if (pwm[1:0] == 2'b10) l1++; else break;
    end
    chk(l1 == 40, "R8 pulse in progress unchanged", l1, 40);
    pulse_len(l2);
    chk(l2 == 80, "R8 next period uses new command", l2, 80);
  endtask

  // R2 R5: one channel, absent channels' currents ignored
  task automatic t_one();
    err = 10'd70; isen = {8'd255, 8'd255, 8'd255, 8'd50};
    do_reset(4'b1110);
    capture();
    chk(highs(0) == 70, "R5 absent currents excluded", highs(0), 70);
    chk(all_hiz(1) && all_hiz(2) && all_hiz(3), "R2 single active", 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_four();
    t_two();
    t_three();
    t_sample();
    t_one();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule